// File: doc/BRIEF.md
# Legacy Unaligned Load/Store Aligner

This block sits between the load/store stage of a processor and a 32-bit memory port that takes word addresses with byte enables. It serves a legacy mode that never raises an alignment fault. Each request gives an access kind, a direction, a byte address, store data and, for multi-word transfers, a word count. The block turns the request into one or more aligned memory beats and shapes the data that comes back. Low address bits that the access cannot honour are dropped without a fault. The exception is an ordinary word load, where the aligned word is returned rotated so that the addressed byte lands in the low lane. Every request whose address would make its result architecturally unpredictable raises a flag for the length of the transaction.

The processor presents a request while `req_ready` is high. The block registers it, and from the next cycle it drives one beat at a time on the memory port. A beat completes on every cycle that `mem_ready` is high. The memory returns load data in the same cycle as its ready. The shaped load result follows one cycle later on `ld_data`. After the last beat, `done` pulses for one cycle and `req_ready` is high again. During a two-word or multi-word store, the caller presents the data for the next beat on `req_wdata` whenever a beat completes.

Kind codes on `req_kind`:

| Code | Kind |
|------|------|
| 0 | byte |
| 1 | synchronising byte |
| 2 | halfword |
| 3 | synchronising halfword |
| 4 | word |
| 5 | synchronising word |
| 6 | two-word |
| 7 | synchronising double-word |
| 8 | multi-word |

Codes 9 to 15 behave as byte.

Top module: `ldst_aligner`

## Requirements
- R1: A word load (kind 4) at byte address A drives one beat to A with bits [1:0] cleared, with `mem_be`=4'b1111 and the flag low. It returns the fetched word rotated right by 8*A[1:0] bits.
- R2: A word store (kind 4) drives one beat to A with bits [1:0] cleared, with `mem_be`=4'b1111 and `mem_wdata` equal to `req_wdata`, whatever the value of A[1:0]. The flag stays low.
- R3: A byte access (kind 0 or 1) drives the aligned word address with only enable bit A[1:0] set. A store puts `req_wdata[7:0]` on all four lanes. A load returns byte lane A[1:0], zero-extended; lane n is bits [8n+7:8n]. The flag stays low.
- R4: A halfword access (kind 2 or 3) clears A[0]. Its enables are 4'b0011 when A[1]=0 and 4'b1100 when A[1]=1. A store puts `req_wdata[15:0]` on both halves. A load returns the selected half, zero-extended. The flag is high exactly when A[0]=1.
- R5: A synchronising word access (kind 5) drives the aligned word with all enables set. A load returns the word without rotation. The flag is high exactly when A[1:0]!=0.
- R6: A two-word access (kind 6 or 7) drives two beats, at A with bits [2:0] cleared and at that address plus 4, all enables set. A load returns each word unchanged. The flag is high exactly when A[2:0]!=0.
- R7: A multi-word access (kind 8) drives `req_count` beats, or one beat when the count is 0. The beats start at A with bits [1:0] cleared and each beat adds 4. All enables are set, loads return each word unchanged, and the flag stays low.
- R8: While `mem_ready` is low, the address, enables and write data hold. A request presented while a transaction is in flight has no effect on it. For burst stores, `req_wdata` sampled when a non-final beat completes becomes the next beat's data.
- R9: Each load beat produces `ld_valid` with its result one cycle after the beat completes. `done` pulses one cycle after the final beat, with `mem_valid` low and `req_ready` high in that cycle.
- R10: The unpredictable flag is high only while a transaction is in flight on the memory port.
- R11: A synchronous active-high reset, even in the middle of a burst, leaves `mem_valid`, `done`, `ld_valid` and the flag low and `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 4 | Access kind code |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Store data; next-beat data during bursts |
| req_count | input | CW | Word count for multi-word |
| req_ready | output | 1 | Idle, can take a request |
| mem_valid | output | 1 | Beat on the memory port |
| mem_addr | output | AW | Word-aligned beat address |
| mem_we | output | 1 | Beat is a write |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data in lane position |
| mem_ready | input | 1 | Memory completes the beat this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| ld_valid | output | 1 | Shaped load result valid |
| ld_data | output | 32 | Shaped load result |
| unpred | output | 1 | Current transaction is architecturally unpredictable |
| done | output | 1 | Transaction finished pulse |

## Verification
The properties assume the following:
- Reset is held across at least one clock edge before traffic starts.
- `mem_rdata` is meaningful only in cycles where `mem_ready` is high.
- A burst never runs past the top of the address space, since the step check compares against the previous address plus 4 without wrap.

The stimulus keeps every address inside a 256-byte memory model, well clear of wrap, and uses counts up to eight. It stalls the port on a fixed pattern and holds a conflicting request high through one burst, so the hold and ignore properties are exercised without breaking those assumptions.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  localparam logic [3:0] K_BYTE   = 4'd0;
  localparam logic [3:0] K_BYTE_S = 4'd1;
  localparam logic [3:0] K_HALF   = 4'd2;
  localparam logic [3:0] K_HALF_S = 4'd3;
  localparam logic [3:0] K_WORD   = 4'd4;
  localparam logic [3:0] K_WORD_S = 4'd5;
  localparam logic [3:0] K_PAIR   = 4'd6;
  localparam logic [3:0] K_PAIR_S = 4'd7;
  localparam logic [3:0] K_MULTI  = 4'd8;

  // how returned data is shaped
  typedef enum logic [1:0] {
    LX_BYTE = 2'd0,
    LX_HALF = 2'd1,
    LX_ROT  = 2'd2,
    LX_RAW  = 2'd3
  } ldx_e;

  // store data width class
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;
endpackage

// File: rtl/lsa_decode.sv
module lsa_decode
  import lsa_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic [3:0]        kind,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [CW-1:0]     count,
  output logic [AW-1:0]     base,
  output logic [LANES-1:0]  be,
  output logic [CW-1:0]     beats,
  output logic              unp,
  output logic [WORD_W-1:0] wlane,
  output ldx_e              ldx,
  output logic [1:0]        ofs
);
  size_e size;

  always_comb begin
    base  = {addr[AW-1:2], 2'b00};
    be    = {LANES{1'b1}};
    beats = CW'(1);
    unp   = 1'b0;
    ldx   = LX_RAW;
    ofs   = addr[1:0];
    size  = SZ_WORD;
    case (kind)
      K_HALF, K_HALF_S: begin
        size = SZ_HALF;
        be   = addr[1] ? 4'b1100 : 4'b0011;
        unp  = addr[0];
        ldx  = LX_HALF;
      end
      K_WORD: ldx = LX_ROT;
      K_WORD_S: unp = |addr[1:0];
      K_PAIR, K_PAIR_S: begin
        base  = {addr[AW-1:3], 3'b000};
        beats = CW'(2);
        unp   = |addr[2:0];
      end
      K_MULTI: beats = (count == '0) ? CW'(1) : count;
      default: begin
        size = SZ_BYTE;
        be   = 4'b0001 << addr[1:0];
        ldx  = LX_BYTE;
      end
    endcase
  end

  // place store data into every byte lane it may occupy
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wlane[8*g +: 8] = (size == SZ_BYTE) ? wdata[7:0] :
                             (size == SZ_HALF) ? wdata[8*(g%2) +: 8] :
                                                 wdata[8*g +: 8];
  end
endmodule

// File: rtl/lsa_seq.sv
module lsa_seq
  import lsa_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [AW-1:0]     d_base,
  input  logic [LANES-1:0]  d_be,
  input  logic [CW-1:0]     d_beats,
  input  logic              d_unp,
  input  logic [WORD_W-1:0] d_wlane,
  input  ldx_e              d_ldx,
  input  logic [1:0]        d_ofs,
  input  logic              mem_ready,
  output logic              req_ready,
  output logic              mem_valid,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              unpred,
  output logic              done,
  output ldx_e              ldx_q,
  output logic [1:0]        ofs_q
);
  localparam logic [AW-1:0] STEP = AW'(LANES);

  logic [CW-1:0] left;
  logic          last_beat;

  assign req_ready = !mem_valid;
  assign last_beat = (left == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_be    <= '0;
      mem_wdata <= '0;
      unpred    <= 1'b0;
      done      <= 1'b0;
      left      <= '0;
      ldx_q     <= LX_RAW;
      ofs_q     <= 2'b00;
    end else begin
      done <= 1'b0;
      if (!mem_valid) begin
        if (req_valid) begin
          mem_valid <= 1'b1;
          mem_addr  <= d_base;
          mem_we    <= req_write;
          mem_be    <= d_be;
          mem_wdata <= d_wlane;
          unpred    <= d_unp;
          left      <= d_beats;
          ldx_q     <= d_ldx;
          ofs_q     <= d_ofs;
        end
      end else if (mem_ready) begin
        if (last_beat) begin
          mem_valid <= 1'b0;
          unpred    <= 1'b0;
          done      <= 1'b1;
        end else begin
          mem_addr  <= mem_addr + STEP;
          mem_wdata <= req_wdata;
          left      <= left - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lsa_lane.sv
module lsa_lane
  import lsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_rd,
  input  ldx_e              ldx,
  input  logic [1:0]        ofs,
  input  logic [WORD_W-1:0] rdata,
  output logic              ld_valid,
  output logic [WORD_W-1:0] ld_data
);
  logic [2*WORD_W-1:0] dbl;
  logic [WORD_W-1:0]   shaped;

  assign dbl = {rdata, rdata};

  always_comb begin
    case (ldx)
      LX_BYTE: shaped = {{(WORD_W-8){1'b0}}, rdata[{ofs, 3'b000} +: 8]};
      LX_HALF: shaped = {{(WORD_W-16){1'b0}}, (ofs[1] ? rdata[31:16] : rdata[15:0])};
      LX_ROT:  shaped = dbl[{ofs, 3'b000} +: WORD_W];
      default: shaped = rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= beat_rd;
      if (beat_rd) ld_data <= shaped;
    end
  end
endmodule

// File: rtl/ldst_aligner.sv
module ldst_aligner
  import lsa_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_kind,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [CW-1:0]     req_count,
  output logic              req_ready,
  output logic              mem_valid,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              ld_valid,
  output logic [31:0]       ld_data,
  output logic              unpred,
  output logic              done
);
  logic [AW-1:0]     d_base;
  logic [LANES-1:0]  d_be;
  logic [CW-1:0]     d_beats;
  logic              d_unp;
  logic [WORD_W-1:0] d_wlane;
  ldx_e              d_ldx;
  logic [1:0]        d_ofs;
  ldx_e              ldx_q;
  logic [1:0]        ofs_q;

  lsa_decode #(.AW(AW), .CW(CW)) u_dec (
    .kind(req_kind), .addr(req_addr), .wdata(req_wdata), .count(req_count),
    .base(d_base), .be(d_be), .beats(d_beats), .unp(d_unp),
    .wlane(d_wlane), .ldx(d_ldx), .ofs(d_ofs)
  );

  lsa_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .d_base(d_base), .d_be(d_be), .d_beats(d_beats),
    .d_unp(d_unp), .d_wlane(d_wlane), .d_ldx(d_ldx), .d_ofs(d_ofs),
    .mem_ready(mem_ready), .req_ready(req_ready), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .unpred(unpred), .done(done),
    .ldx_q(ldx_q), .ofs_q(ofs_q)
  );

  lsa_lane u_lane (
    .clk(clk), .rst(rst), .beat_rd(mem_valid && mem_ready && !mem_we),
    .ldx(ldx_q), .ofs(ofs_q), .rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );
endmodule

// File: rtl/lsa_chk.sv
module lsa_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic [31:0]   mem_wdata,
  input logic          ld_valid,
  input logic          unpred,
  input logic          done,
  input logic          req_ready
);
  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> mem_addr[1:0] == 2'b00); // R1
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> ($countones(mem_be) == 1 || mem_be == 4'b0011 ||
                   mem_be == 4'b1100 || mem_be == 4'b1111)); // R3
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_be) && $stable(mem_wdata) && $stable(mem_we)); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ready |=> !mem_valid || mem_addr == $past(mem_addr) + AW'(4)); // R7
  AST_BURST_FULL: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ready |=> !mem_valid || mem_be == 4'b1111); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_valid && mem_ready) && !mem_valid && req_ready); // R9
  AST_LD_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(mem_valid && mem_ready && !mem_we)); // R9
  AST_UNPRED_IN_TXN: assert property (@(posedge clk) disable iff (rst)
    unpred |-> mem_valid); // R10
endmodule

bind ldst_aligner lsa_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
  .mem_wdata(mem_wdata), .ld_valid(ld_valid), .unpred(unpred),
  .done(done), .req_ready(req_ready)
);

// File: tb/sim_ldst_aligner.sv
module sim_ldst_aligner;
  import lsa_pkg::*;
  localparam int CLK_NS = 10;
  localparam int AW = 32;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_NS/2) clk = ~clk;

  logic          req_valid = 1'b0;
  logic [3:0]    req_kind = '0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [CW-1:0] req_count = '0;
  logic          req_ready, mem_valid, mem_we, ld_valid, unpred, done;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata, mem_rdata, ld_data;
  logic          mem_ready = 1'b0;

  ldst_aligner #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_count(req_count), .req_ready(req_ready), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .unpred(unpred), .done(done)
  );

  // memory model: byte address b holds value b after reset
  logic [31:0] mem [64];
  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= fillw(8'(4*i));
    end else if (mem_valid && mem_ready && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  function automatic logic [31:0] fillw(input logic [7:0] a);
    logic [7:0] w;
    w = {a[7:2], 2'b00};
    return {w + 8'd3, w + 8'd2, w + 8'd1, w};
  endfunction

  function automatic logic [31:0] rot_exp(input logic [7:0] a);
    logic [31:0] r;
    logic [7:0]  w;
    w = {a[7:2], 2'b00};
    for (int k = 0; k < 4; k++) r[8*k +: 8] = w + 8'((k + int'(a[1:0])) % 4);
    return r;
  endfunction

  int nchk = 0, nfail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // results of the last transaction
  logic [31:0] b_addr [33];
  logic [3:0]  b_be   [33];
  logic [31:0] b_wd   [33];
  logic [31:0] b_ld   [33];
  logic [31:0] bwd    [33];
  int          nb, nld;
  logic        r_unp, r_done_ok, r_hold_ok;

  task automatic run(input logic [3:0] k, input bit wr, input logic [31:0] a,
                     input logic [CW-1:0] cnt, input bit stall, input bit noise);
    bit pend;
    bit sprev;
    logic [31:0] h_addr, h_wd;
    logic [3:0]  h_be;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_write = wr; req_addr = a;
    req_wdata = bwd[0]; req_count = cnt; mem_ready = 1'b0;
    @(negedge clk);
    if (noise) begin
      req_kind = K_BYTE; req_addr = 32'h0000_000C; req_write = 1'b1;
    end else req_valid = 1'b0;
    nb = 0; nld = 0; r_unp = unpred; pend = 0; sprev = 0; r_hold_ok = 1'b1;
    h_addr = '0; h_wd = '0; h_be = '0;
    for (int c = 0; c < 200; c++) begin
      if (pend) begin
        if (ld_valid) begin b_ld[nld] = ld_data; nld++; end
        pend = 0;
      end
      if (!mem_valid) break;
      if (sprev && (mem_addr !== h_addr || mem_be !== h_be || mem_wdata !== h_wd))
        r_hold_ok = 1'b0;
      if (stall && (c % 3 == 0)) begin
        mem_ready = 1'b0; sprev = 1;
        h_addr = mem_addr; h_be = mem_be; h_wd = mem_wdata;
      end else begin
        mem_ready = 1'b1; sprev = 0;
        b_addr[nb] = mem_addr; b_be[nb] = mem_be; b_wd[nb] = mem_wdata;
        nb++;
        req_wdata = bwd[nb];
        pend = !mem_we;
      end
      @(negedge clk);
    end
    r_done_ok = done && req_ready && !mem_valid;
    mem_ready = 1'b0; req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 mem_valid", 32'(mem_valid), 0);
    chk("R11 req_ready", 32'(req_ready), 1);
    chk("R11 done", 32'(done), 0);
    chk("R11 ld_valid", 32'(ld_valid), 0);
    chk("R11 unpred", 32'(unpred), 0);
  endtask

  task automatic t_word_load;
    for (int o = 0; o < 4; o++) begin
      run(K_WORD, 0, 32'h40 + 32'(o), 0, 0, 0);
      chk("R1 beats", 32'(nb), 1);
      chk("R1 addr", b_addr[0], 32'h40);
      chk("R1 be", 32'(b_be[0]), 32'hF);
      chk("R1 data", b_ld[0], rot_exp(8'(8'h40 + o)));
      chk("R1 unpred", 32'(r_unp), 0);
      chk("R9 done", 32'(r_done_ok), 1);
    end
  endtask

  task automatic t_word_store;
    bwd[0] = 32'hA1B2_C3D4;
    run(K_WORD, 1, 32'h51, 0, 0, 0);
    chk("R2 addr", b_addr[0], 32'h50);
    chk("R2 be", 32'(b_be[0]), 32'hF);
    chk("R2 wdata", b_wd[0], 32'hA1B2_C3D4);
    chk("R2 unpred", 32'(r_unp), 0);
    run(K_WORD_S, 0, 32'h50, 0, 0, 0);
    chk("R2 readback", b_ld[0], 32'hA1B2_C3D4);
  endtask

  task automatic t_byte;
    run(K_BYTE, 0, 32'h42, 0, 0, 0);
    chk("R3 addr", b_addr[0], 32'h40);
    chk("R3 be", 32'(b_be[0]), 32'b0100);
    chk("R3 data", b_ld[0], 32'h42);
    run(K_BYTE_S, 0, 32'h47, 0, 0, 0);
    chk("R3 be sync", 32'(b_be[0]), 32'b1000);
    chk("R3 data sync", b_ld[0], 32'h47);
    chk("R3 unpred", 32'(r_unp), 0);
    bwd[0] = 32'h1234_565A;
    run(K_BYTE, 1, 32'h63, 0, 0, 0);
    chk("R3 store be", 32'(b_be[0]), 32'b1000);
    chk("R3 store wdata", b_wd[0], 32'h5A5A_5A5A);
    run(K_WORD_S, 0, 32'h60, 0, 0, 0);
    chk("R3 readback", b_ld[0], 32'h5A62_6160);
  endtask

  task automatic t_half;
    run(K_HALF, 0, 32'h42, 0, 0, 0);
    chk("R4 be", 32'(b_be[0]), 32'b1100);
    chk("R4 data", b_ld[0], 32'h4342);
    chk("R4 unpred even", 32'(r_unp), 0);
    run(K_HALF_S, 0, 32'h43, 0, 0, 0);
    chk("R4 be odd", 32'(b_be[0]), 32'b1100);
    chk("R4 data odd", b_ld[0], 32'h4342);
    chk("R4 unpred odd", 32'(r_unp), 1);
    run(K_HALF, 0, 32'h41, 0, 0, 0);
    chk("R4 be low", 32'(b_be[0]), 32'b0011);
    chk("R4 data low", b_ld[0], 32'h4140);
    bwd[0] = 32'h7777_BEEF;
    run(K_HALF, 1, 32'h6D, 0, 0, 0);
    chk("R4 store addr", b_addr[0], 32'h6C);
    chk("R4 store be", 32'(b_be[0]), 32'b0011);
    chk("R4 store wdata", b_wd[0], 32'hBEEF_BEEF);
    chk("R4 store unpred", 32'(r_unp), 1);
  endtask

  task automatic t_wsync;
    run(K_WORD_S, 0, 32'h46, 0, 0, 0);
    chk("R5 addr", b_addr[0], 32'h44);
    chk("R5 be", 32'(b_be[0]), 32'hF);
    chk("R5 data", b_ld[0], 32'h4746_4544);
    chk("R5 unpred", 32'(r_unp), 1);
    run(K_WORD_S, 0, 32'h44, 0, 0, 0);
    chk("R5 unpred aligned", 32'(r_unp), 0);
  endtask

  task automatic t_pair;
    run(K_PAIR, 0, 32'h48, 0, 1, 0);
    chk("R6 beats", 32'(nb), 2);
    chk("R6 addr0", b_addr[0], 32'h48);
    chk("R6 addr1", b_addr[1], 32'h4C);
    chk("R6 data1", b_ld[1], fillw(8'h4C));
    chk("R6 unpred", 32'(r_unp), 0);
    chk("R8 hold", 32'(r_hold_ok), 1);
    run(K_PAIR_S, 0, 32'h4D, 0, 0, 0);
    chk("R6 sync addr0", b_addr[0], 32'h48);
    chk("R6 sync unpred", 32'(r_unp), 1);
    bwd[0] = 32'h1111_1111; bwd[1] = 32'h2222_2222;
    run(K_PAIR, 1, 32'h74, 0, 1, 0);
    chk("R6 store addr0", b_addr[0], 32'h70);
    chk("R6 store wd1", b_wd[1], 32'h2222_2222);
    chk("R6 store be1", 32'(b_be[1]), 32'hF);
    chk("R6 store unpred", 32'(r_unp), 1);
    chk("R9 done pair", 32'(r_done_ok), 1);
  endtask

  task automatic t_multi;
    run(K_MULTI, 0, 32'h23, 5, 1, 0);
    chk("R7 beats", 32'(nb), 5);
    for (int i = 0; i < 5; i++) begin
      chk("R7 addr", b_addr[i], 32'h20 + 32'(4*i));
      chk("R7 data", b_ld[i], fillw(8'(8'h20 + 4*i)));
    end
    chk("R9 ld count", 32'(nld), 5);
    chk("R7 unpred", 32'(r_unp), 0);
    run(K_MULTI, 0, 32'h31, 0, 0, 0);
    chk("R7 zero count", 32'(nb), 1);
    chk("R7 zero addr", b_addr[0], 32'h30);
    for (int i = 0; i < 4; i++) bwd[i] = 32'hC0DE_0000 + 32'(i);
    run(K_MULTI, 1, 32'h82, 3, 1, 0);
    chk("R8 store wd2", b_wd[2], 32'hC0DE_0002);
    chk("R7 store addr2", b_addr[2], 32'h88);
    run(K_MULTI, 0, 32'h80, 3, 0, 0);
    chk("R8 readback", b_ld[1], 32'hC0DE_0001);
  endtask

  task automatic t_noise;
    run(K_MULTI, 0, 32'h10, 4, 1, 1);
    chk("R8 ignore beats", 32'(nb), 4);
    chk("R8 ignore addr3", b_addr[3], 32'h1C);
    chk("R8 ignore kind", b_ld[3], fillw(8'h1C));
    chk("R9 done noise", 32'(r_done_ok), 1);
    @(negedge clk);
    chk("R9 done pulse", 32'(done), 0);
    chk("R10 unpred idle", 32'(unpred), 0);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    req_valid = 1'b1; req_kind = K_MULTI; req_write = 1'b0;
    req_addr = 32'h40; req_count = 8;
    @(negedge clk);
    req_valid = 1'b0; mem_ready = 1'b1;
    @(negedge clk);
    rst = 1'b1; mem_ready = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 mid mem_valid", 32'(mem_valid), 0);
    chk("R11 mid req_ready", 32'(req_ready), 1);
    chk("R11 mid ld_valid", 32'(ld_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 33; i++) bwd[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_word_load();
    t_word_store();
    t_byte();
    t_half();
    t_wsync();
    t_pair();
    t_multi();
    t_noise();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule